// File: doc/BRIEF.md
# JTAG Scan-Chain Register Access Port

This block lets a debug host read and write a bank of 32-bit configuration registers over one JTAG data-register chain. It sits behind an existing TAP controller. From that controller it takes TCK, TDI, the chain-select value and the Capture-DR, Shift-DR and Update-DR state strobes, and it drives TDO. Each strobe is a level that is high for the TCK cycles the TAP spends in that state. The block acts on a strobe only while the chain-select value equals the chain number of this block, which is 6 by default.

Each scan moves one 40-bit packet through the chain. The packet holds a data word, a 7-bit register address and a direction flag. A write packet commits its data word to the addressed register when the TAP enters Update-DR. A read packet copies the addressed register into a holding register at Update-DR. The next Capture-DR loads that value into the low 32 bits of the chain, and the host then shifts it out. The register contents also drive a flat parallel output so that the rest of the chip can use the programmed values.

Top module: `jtag_cfg_port`

## Requirements
- R1: The packet is 40 bits wide. The data word sits in bits [31:0], the address in bits [38:32] and the direction flag in bit 39, where 1 means write and 0 means read. The first bit shifted in from TDI ends up in bit 0.
- R2: A write packet whose address is below NUM_REGS (16) stores its data word in that register at the rising TCK edge on which Update-DR is sampled.
- R3: A write packet whose address is NUM_REGS or higher changes no register.
- R4: A read packet copies the addressed register, or zero when the address is NUM_REGS or higher, into the holding register at Update-DR. The next Capture-DR loads that value into bits [31:0] of the chain, and the value then leaves on TDO LSB first.
- R5: The data word of a read packet has no effect on any register.
- R6: No register in the bank changes during Capture-DR or Shift-DR. Registers change only at Update-DR.
- R7: When the chain-select value differs from CHAIN_ID (6), the capture, shift and update strobes are ignored: the bank does not change and TDO holds its value.
- R8: TDO changes only on the falling edge of TCK, and it then takes the value of bit 0 of the chain.
- R9: A synchronous active-high reset, sampled on rising TCK, clears the chain, the holding register, every bank register and TDO.
- R10: Register k drives bits [32k+31:32k] of regs_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial data in |
| chain_sel | input | SEL_W (4) | Chain number chosen by the TAP |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| regs_out | output | NUM_REGS*32 | Parallel contents of the register bank |

## Verification
The bench writes every one of the 128 addresses and then reads every one back. This catches two faults: a design that folds addresses 16 to 127 onto the implemented slots, which overwrites real registers, and a design that returns stale data for unimplemented reads instead of zero. The read sweep is pipelined, so each result comes back one scan late. This exposes a design that loads the holding register late, or that captures the current register instead of the one latched at the previous Update-DR. The bench also compares the bank outputs on every shift cycle, which catches a design that commits a write early. It scans with the wrong chain number in the middle of a capture-and-shift sequence. A design that kept shifting would then return a misaligned word, and a design that applied the update would change the bank. Finally, it times the TDO change against both clock edges, which catches a design that updates TDO on the rising edge.

// File: rtl/jcp_pkg.sv
package jcp_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 7;
  parameter int PKT_W  = DATA_W + ADDR_W + 1;

  // The field order matters for behaviour: bit 0 is shifted first.
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/jcp_shifter.sv
module jcp_shifter
  import jcp_pkg::*;
(
  input  logic              tck,
  input  logic              rst,
  input  logic              sel_ok,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output pkt_t              pkt,
  output logic              tdo
);
  logic [PKT_W-1:0] sr;

  always_ff @(posedge tck) begin
    if (rst) begin
      sr <= '0;
    end else if (sel_ok && capture) begin
      sr[DATA_W-1:0] <= cap_data;
    end else if (sel_ok && shift) begin
      sr <= {tdi, sr[PKT_W-1:1]};
    end
  end

  always_ff @(negedge tck) begin
    if (rst) tdo <= 1'b0;
    else     tdo <= sr[0];
  end

  assign pkt = pkt_t'(sr);

  // R7
  unsel_hold_chk: assert property (@(posedge tck) disable iff (rst)
    !sel_ok |=> $stable(sr));

  // R4
  capture_load_chk: assert property (@(posedge tck) disable iff (rst)
    (sel_ok && capture) |=> sr[DATA_W-1:0] == $past(cap_data));
endmodule

// File: rtl/jcp_bank.sv
module jcp_bank
  import jcp_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                       tck,
  input  logic                       rst,
  input  logic                       upd,
  input  pkt_t                       pkt,
  output logic [DATA_W-1:0]          hold,
  output logic [NUM_REGS*DATA_W-1:0] regs_out
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  assign in_range = {1'b0, pkt.addr} < LIMIT;
  assign idx      = pkt.addr[IDX_W-1:0];

  always_ff @(posedge tck) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      hold <= '0;
    end else if (upd) begin
      if (pkt.wr) begin
        if (in_range) mem[idx] <= pkt.data;
      end else begin
        hold <= in_range ? mem[idx] : '0;
      end
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_out
    assign regs_out[k*DATA_W +: DATA_W] = mem[k];
  end

  // R6
  idle_stable_chk: assert property (@(posedge tck) disable iff (rst)
    !upd |=> $stable(regs_out) && $stable(hold));

  // R2
  wr_commit_chk: assert property (@(posedge tck) disable iff (rst)
    (upd && pkt.wr && in_range) |=> mem[$past(idx)] == $past(pkt.data));

  // R3
  wr_drop_chk: assert property (@(posedge tck) disable iff (rst)
    (upd && pkt.wr && !in_range) |=> $stable(regs_out));

  // R5
  rd_keep_chk: assert property (@(posedge tck) disable iff (rst)
    (upd && !pkt.wr) |=> $stable(regs_out));

  // R4
  rd_zero_chk: assert property (@(posedge tck) disable iff (rst)
    (upd && !pkt.wr && !in_range) |=> hold == '0);

  // R9
  rst_clear_chk: assert property (@(posedge tck)
    rst |=> (hold == '0) && (regs_out == '0));
endmodule

// File: rtl/jtag_cfg_port.sv
module jtag_cfg_port
  import jcp_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int SEL_W    = 4,
  parameter int CHAIN_ID = 6
) (
  input  logic                       tck,
  input  logic                       rst,
  input  logic                       tdi,
  input  logic [SEL_W-1:0]           chain_sel,
  input  logic                       capture_dr,
  input  logic                       shift_dr,
  input  logic                       update_dr,
  output logic                       tdo,
  output logic [NUM_REGS*DATA_W-1:0] regs_out
);
  logic              sel_ok;
  pkt_t              pkt;
  logic [DATA_W-1:0] hold;

  assign sel_ok = (chain_sel == SEL_W'(CHAIN_ID));

  jcp_shifter u_shift (
    .tck      (tck),
    .rst      (rst),
    .sel_ok   (sel_ok),
    .capture  (capture_dr),
    .shift    (shift_dr),
    .tdi      (tdi),
    .cap_data (hold),
    .pkt      (pkt),
    .tdo      (tdo)
  );

  jcp_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .tck      (tck),
    .rst      (rst),
    .upd      (sel_ok && update_dr),
    .pkt      (pkt),
    .hold     (hold),
    .regs_out (regs_out)
  );
endmodule

// File: tb/jtag_cfg_port_test.sv
module jtag_cfg_port_test;
  localparam int NR = 16;

  logic          tck = 1'b0;
  logic          rst = 1'b1;
  logic          tdi = 1'b0;
  logic [3:0]    chain_sel = 4'd6;
  logic          capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic          tdo;
  logic [NR*32-1:0] regs_out;

  int tests = 0, fails = 0;
  logic smp;
  logic [31:0] model [NR];

  always #4 tck = ~tck;

  jtag_cfg_port uut (
    .tck(tck), .rst(rst), .tdi(tdi), .chain_sel(chain_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdo(tdo), .regs_out(regs_out)
  );

  function automatic logic [31:0] pat(int a);
    return (32'h9E3779B1 * (a + 1)) ^ 32'h00FF0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic tick(bit c, bit s, bit u, bit d, logic [3:0] sl);
    @(negedge tck);
    #1;
    capture_dr = c; shift_dr = s; update_dr = u; tdi = d; chain_sel = sl;
    #1 smp = tdo;
    @(posedge tck);
  endtask

  task automatic scan(input logic [39:0] pk, input logic [3:0] sl,
                      output logic [39:0] got, output bit moved);
    logic [NR*32-1:0] snap;
    snap = regs_out;
    moved = 0;
    tick(1, 0, 0, 0, sl);
    for (int i = 0; i < 40; i++) begin
      tick(0, 1, 0, pk[i], sl);
      got[i] = smp;
      if (regs_out !== snap) moved = 1;
    end
    tick(0, 0, 1, 0, sl);
    tick(0, 0, 0, 0, 4'd6);
    #1;
  endtask

  function automatic logic [39:0] mk(bit wr, int a, logic [31:0] d);
    return {wr, 7'(a), d};
  endfunction

  task automatic cmp_bank(string req);
    int bad = 0;
    for (int k = 0; k < NR; k++)
      if (regs_out[k*32 +: 32] !== model[k]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick(0, 0, 0, 0, 4'd6);
    rst = 1'b0;
    for (int k = 0; k < NR; k++) model[k] = '0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    logic [39:0] got;
    bit moved;

    do_reset();
    cmp_bank("R9 bank clear");
    @(negedge tck); #1;
    chk("R9 tdo clear", 32'(tdo), 32'd0);

    // R2 R3 R6 R10: write every address
    for (int a = 0; a < 128; a++) begin
      scan(mk(1, a, pat(a)), 4'd6, got, moved);
      if (a < NR) model[a] = pat(a);
      if (a == 0 || a == 127) chk("R6 stable while shifting", 32'(moved), 32'd0);
      if (a < NR) cmp_bank("R2 write commit");
      else if (a == NR || a == 127) cmp_bank("R3 unimplemented write dropped");
    end
    for (int k = 0; k < NR; k++)
      chk("R10 regs_out slice", regs_out[k*32 +: 32], pat(k));

    // R4 R5: pipelined read sweep, data field filled with junk
    scan(mk(0, 0, 32'hDEADBEEF), 4'd6, got, moved);
    for (int a = 1; a <= 128; a++) begin
      scan(mk(0, a % 128, ~pat(a)), 4'd6, got, moved);
      chk("R4 read back", got[31:0], (a - 1 < NR) ? pat(a - 1) : 32'd0);
    end
    cmp_bank("R5 reads leave bank alone");

    // R1: LSB-first ordering and flag position
    scan(mk(1, 5, 32'h0000_0001), 4'd6, got, moved);
    scan(mk(1, 6, 32'h8000_0000), 4'd6, got, moved);
    model[5] = 32'h1; model[6] = 32'h8000_0000;
    chk("R1 bit0 of word", regs_out[5*32 +: 32], 32'h0000_0001);
    chk("R1 bit31 of word", regs_out[6*32 +: 32], 32'h8000_0000);
    scan({1'b0, 7'd5, 32'hFFFF_FFFF}, 4'd6, got, moved);
    cmp_bank("R1 flag 0 is read");

    // R7: wrong chain number ignores write
    scan(mk(1, 3, 32'h1234_5678), 4'd5, got, moved);
    cmp_bank("R7 unselected update ignored");

    // R7: shift stalls while unselected. hold currently = reg5 = 1
    tick(1, 0, 0, 0, 4'd6);
    for (int i = 0; i < 10; i++) begin
      tick(0, 1, 0, i[0], 4'd5);
      if (i == 9) chk("R7 tdo holds while unselected", 32'(smp), 32'd1);
    end
    for (int i = 0; i < 40; i++) begin
      tick(0, 1, 0, 1'b0, 4'd6);
      got[i] = smp;
    end
    chk("R7 word intact after stall", got[31:0], 32'h0000_0001);
    tick(0, 0, 0, 0, 4'd6);

    // R8: tdo changes on the falling edge. Load hold=1, chain bit0=0.
    scan(mk(0, 5, 32'h0), 4'd6, got, moved);
    @(negedge tck); #1;
    chk("R8 tdo before capture", 32'(tdo), 32'd0);
    capture_dr = 1'b1;
    @(posedge tck); #1;
    capture_dr = 1'b0;
    chk("R8 tdo steady after rising edge", 32'(tdo), 32'd0);
    @(negedge tck); #1;
    chk("R8 tdo after falling edge", 32'(tdo), 32'd1);

    // R9: mid-run reset clears bank and hold
    do_reset();
    cmp_bank("R9 bank clear after use");
    scan(mk(0, 2, 32'h0), 4'd6, got, moved);
    scan(mk(0, 2, 32'h0), 4'd6, got, moved);
    chk("R9 read after reset", got[31:0], 32'd0);

    summary();
  end
endmodule